// File: doc/BRIEF.md
# Single-Channel Memory Copy Engine

This block moves a run of equal-sized items from one place in the address space to another while the processor is busy with other work. Software loads a start address for reading, a start address for writing, an item count and a control word that picks the item size (1, 2 or 4 bytes) and the direction of the copy. Writing the control word with its start bit set launches the channel. The total bytes moved are the item count times the item size.

For every item the engine takes the shared memory bus twice. It reads the item, then writes it back out. It raises its bus request and waits, without limit, until the arbiter grants it, because the processor may be holding the bus. The direction sets how each side's address moves between items. In memory-to-memory mode both addresses advance by the item size. In peripheral-to-memory mode the read address stays on one fixed data register and the write address advances. In memory-to-peripheral mode the read address advances and the write address stays fixed. When the last write has been granted, a sticky done flag is set and drives the interrupt line. Software may use the destination buffer only after that point.

The register port is a plain write strobe with an address. Read data is combinational from the register address.

| Address | Name | Contents |
|---|---|---|
| 0 | source | read start address |
| 1 | destination | write start address |
| 2 | count | item count, low CW bits |
| 3 | control | bits [1:0] item size code, bits [3:2] direction, bit 4 start (write only) |
| 4 | status | bit0 done, bit1 error, bit2 busy |

- Item size codes: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = invalid.
- Direction codes: 0 = memory-to-memory, 1 = peripheral-to-memory, 2 = memory-to-peripheral, 3 = treated as memory-to-memory.
- The control register reads back {direction, size} in bits [3:0].
- The done and error bits in the status register are cleared by writing 1 to them.

Top module: `dma_engine`

## Requirements
- R1: After reset, bus_req and irq are low and the status register reads 0.
- R2: Each item is one granted read (bus_we=0) followed by one granted write (bus_we=1). The write data equals the data returned by that item's read, and bus_size carries the item size code on both accesses.
- R3: With direction 0, item i is read at source + i*size and written at destination + i*size.
- R4: With direction 1, every read uses the source address unchanged, and item i is written at destination + i*size.
- R5: With direction 2, item i is read at source + i*size, and every write uses the destination address unchanged.
- R6: While bus_req is high and bus_gnt is low, the engine holds bus_req high and keeps bus_addr, bus_we and bus_wdata unchanged on the next cycle.
- R7: irq (status bit0) stays low until the final write is granted and is high on the cycle after it. It then stays high until software writes 1 to status bit0, which clears it.
- R8: A start with size code 3, or with a source or destination address not aligned to the item size, sets status bit1 and issues no bus cycle. Writing 1 to status bit1 clears it.
- R9: A start with count 0 sets status bit0 and irq at the clock edge that takes the start write, and issues no bus cycle.
- R10: While a transfer is active, writes to registers 0 to 3 (including a new start) have no effect. The running copy keeps its original addresses, and the registers read back their earlier values.
- R11: Status bit2 reads 1 from the start edge until the final write is granted, and 0 otherwise. bus_req is never high while it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | register write strobe |
| cfg_addr | input | 3 | register address |
| cfg_wdata | input | AW (32) | register write data |
| cfg_rdata | output | AW (32) | register read data, combinational from cfg_addr |
| irq | output | 1 | transfer-complete interrupt (sticky done bit) |
| bus_req | output | 1 | bus request, held until granted |
| bus_gnt | input | 1 | bus grant; an access completes in a cycle with req and gnt both high |
| bus_we | output | 1 | 1 for write, 0 for read |
| bus_addr | output | AW (32) | byte address of the access |
| bus_size | output | 2 | item size code of the access |
| bus_wdata | output | DW (32) | write data |
| bus_rdata | input | DW (32) | read data, valid in the granted read cycle |

## Verification
Every effect of a bad address counter or remaining-item counter shows up at the bus port. The counter bug is exposed on the very next granted access, as a wrong address or an access with the wrong direction bit. A bad item counter shows one item later, as a missing or extra access or an interrupt that comes early or late. A corrupted data holding register shows on the write that follows its read. A stall bug shows in the first cycle without a grant. A wrong start decision for the alignment or zero-count cases shows in the status register on the cycle after the start write.

// File: rtl/dma_pkg.sv
package dma_pkg;

  typedef enum logic [1:0] {
    WID_B1  = 2'd0,
    WID_B2  = 2'd1,
    WID_B4  = 2'd2,
    WID_BAD = 2'd3
  } wid_e;

  typedef enum logic [1:0] {
    DIR_MM  = 2'd0,
    DIR_PM  = 2'd1,
    DIR_MP  = 2'd2,
    DIR_RSV = 2'd3
  } dir_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } st_e;

  localparam logic [2:0] RA_SRC  = 3'd0;
  localparam logic [2:0] RA_DST  = 3'd1;
  localparam logic [2:0] RA_CNT  = 3'd2;
  localparam logic [2:0] RA_CTRL = 3'd3;
  localparam logic [2:0] RA_STAT = 3'd4;

  localparam int CTL_START_BIT = 4;

  // R8: alignment rule for an address's two low bits under a size code
  function automatic logic bad_align(input wid_e w, input logic [1:0] lsb);
    case (w)
      WID_B1:  return 1'b0;
      WID_B2:  return lsb[0];
      WID_B4:  return |lsb;
      default: return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          busy,
  input  logic          set_done,
  input  logic          set_err,
  output logic [AW-1:0] src_q,
  output logic [AW-1:0] dst_q,
  output logic [CW-1:0] cnt_q,
  output wid_e          wid_q,
  output dir_e          dir_q,
  output logic          start,
  output wid_e          start_wid,
  output logic          done_q,
  output logic          err_q,
  output logic [AW-1:0] cfg_rdata
);

  logic cfg_open;
  logic src_en, dst_en, cnt_en, ctl_en, stat_en;
  logic stat_wr;
  logic done_d, err_d;

  // R10: configuration is writable only while the channel is idle
  assign cfg_open = cfg_we && !busy;
  assign src_en   = cfg_open && (cfg_addr == RA_SRC);
  assign dst_en   = cfg_open && (cfg_addr == RA_DST);
  assign cnt_en   = cfg_open && (cfg_addr == RA_CNT);
  assign ctl_en   = cfg_open && (cfg_addr == RA_CTRL);
  assign stat_wr  = cfg_we && (cfg_addr == RA_STAT);

  assign start     = ctl_en && cfg_wdata[CTL_START_BIT];
  assign start_wid = wid_e'(cfg_wdata[1:0]);

  // R7, R8: sticky flags, set has priority over a write-one clear
  always_comb begin
    done_d = done_q;
    err_d  = err_q;
    if (stat_wr && cfg_wdata[0]) done_d = 1'b0;
    if (stat_wr && cfg_wdata[1]) err_d  = 1'b0;
    if (set_done) done_d = 1'b1;
    if (set_err)  err_d  = 1'b1;
  end

  assign stat_en = stat_wr || set_done || set_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      wid_q  <= WID_B1;
      dir_q  <= DIR_MM;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (src_en) src_q <= cfg_wdata;
      if (dst_en) dst_q <= cfg_wdata;
      if (cnt_en) cnt_q <= cfg_wdata[CW-1:0];
      if (ctl_en) begin
        wid_q <= wid_e'(cfg_wdata[1:0]);
        dir_q <= dir_e'(cfg_wdata[3:2]);
      end
      if (stat_en) begin
        done_q <= done_d;
        err_q  <= err_d;
      end
    end
  end

  always_comb begin
    case (cfg_addr)
      RA_SRC:  cfg_rdata = src_q;
      RA_DST:  cfg_rdata = dst_q;
      RA_CNT:  cfg_rdata = AW'(cnt_q);
      RA_CTRL: cfg_rdata = AW'({dir_q, wid_q});
      RA_STAT: cfg_rdata = AW'({busy, err_q, done_q});
      default: cfg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
  import dma_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          adv,
  input  logic [AW-1:0] src_base,
  input  logic [AW-1:0] dst_base,
  input  wid_e          wid,
  input  dir_e          dir,
  output logic [AW-1:0] src_cur,
  output logic [AW-1:0] dst_cur
);

  localparam int NSIDE = 2;  // side 0 reads, side 1 writes

  logic [NSIDE-1:0][AW-1:0] base_all;
  logic [NSIDE-1:0][AW-1:0] cur_all;
  logic [NSIDE-1:0]         hold_all;
  logic [AW-1:0]            stride;

  assign stride      = AW'(1) << wid;
  assign base_all    = {dst_base, src_base};
  // R4, R5: one side parks on a fixed register for peripheral directions
  assign hold_all[0] = (dir == DIR_PM);
  assign hold_all[1] = (dir == DIR_MP);

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    logic [AW-1:0] cur_q;
    logic [AW-1:0] cur_d;
    logic          cur_en;

    always_comb begin
      cur_d = cur_q;
      if (load)                  cur_d = base_all[g];
      else if (adv && !hold_all[g]) cur_d = cur_q + stride;
    end

    assign cur_en = load || adv;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cur_q <= '0;
      else if (cur_en) cur_q <= cur_d;
    end

    assign cur_all[g] = cur_q;
  end

  assign src_cur = cur_all[0];
  assign dst_cur = cur_all[1];

endmodule

// File: rtl/dma_fsm.sv
module dma_fsm
  import dma_pkg::*;
#(
  parameter int CW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  wid_e          start_wid,
  input  logic [CW-1:0] cnt,
  input  logic [1:0]    src_lsb,
  input  logic [1:0]    dst_lsb,
  input  logic          bus_gnt,
  input  logic [DW-1:0] bus_rdata,
  output logic          busy,
  output logic          bus_req,
  output logic          bus_we,
  output logic          load,
  output logic          adv,
  output logic          set_done,
  output logic          set_err,
  output logic [DW-1:0] data_q
);

  st_e           state_q, state_d;
  logic [CW-1:0] rem_q, rem_d;
  logic          cap;
  logic          rem_en;

  always_comb begin
    state_d  = state_q;
    rem_d    = rem_q;
    load     = 1'b0;
    adv      = 1'b0;
    set_done = 1'b0;
    set_err  = 1'b0;
    cap      = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          if (bad_align(start_wid, src_lsb) || bad_align(start_wid, dst_lsb)) begin
            set_err = 1'b1;                 // R8
          end else if (cnt == '0) begin
            set_done = 1'b1;                // R9
          end else begin
            load    = 1'b1;
            rem_d   = cnt;
            state_d = ST_READ;
          end
        end
      end
      ST_READ: begin
        if (bus_gnt) begin
          cap     = 1'b1;
          state_d = ST_WRITE;
        end
      end
      ST_WRITE: begin
        if (bus_gnt) begin
          adv = 1'b1;
          if (rem_q == CW'(1)) begin
            set_done = 1'b1;                // R7
            state_d  = ST_IDLE;
          end else begin
            rem_d   = rem_q - CW'(1);
            state_d = ST_READ;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign rem_en = load || adv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      if (rem_en) rem_q  <= rem_d;
      if (cap)    data_q <= bus_rdata;
    end
  end

  assign busy    = (state_q != ST_IDLE);
  assign bus_req = busy;
  assign bus_we  = (state_q == ST_WRITE);

endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [AW-1:0] cfg_wdata,
  output logic [AW-1:0] cfg_rdata,
  output logic          irq,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [1:0]    bus_size,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata
);

  logic [1:0]    rst_pipe;
  logic          rst_q_n;
  logic [AW-1:0] src_q, dst_q, src_cur, dst_cur;
  logic [CW-1:0] cnt_q;
  wid_e          wid_q, start_wid;
  dir_e          dir_q;
  logic          start, busy, load, adv, set_done, set_err, done_q, err_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  dma_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .busy      (busy),
    .set_done  (set_done),
    .set_err   (set_err),
    .src_q     (src_q),
    .dst_q     (dst_q),
    .cnt_q     (cnt_q),
    .wid_q     (wid_q),
    .dir_q     (dir_q),
    .start     (start),
    .start_wid (start_wid),
    .done_q    (done_q),
    .err_q     (err_q),
    .cfg_rdata (cfg_rdata)
  );

  dma_fsm #(.CW(CW), .DW(DW)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .start     (start),
    .start_wid (start_wid),
    .cnt       (cnt_q),
    .src_lsb   (src_q[1:0]),
    .dst_lsb   (dst_q[1:0]),
    .bus_gnt   (bus_gnt),
    .bus_rdata (bus_rdata),
    .busy      (busy),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .load      (load),
    .adv       (adv),
    .set_done  (set_done),
    .set_err   (set_err),
    .data_q    (bus_wdata)
  );

  dma_addr_gen #(.AW(AW)) u_addr (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .load     (load),
    .adv      (adv),
    .src_base (src_q),
    .dst_base (dst_q),
    .wid      (wid_q),
    .dir      (dir_q),
    .src_cur  (src_cur),
    .dst_cur  (dst_cur)
  );

  assign bus_addr = bus_we ? dst_cur : src_cur;
  assign bus_size = wid_q;
  assign irq      = done_q;

endmodule

// File: rtl/dma_engine_chk.sv
module dma_engine_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          irq,
  input logic          err_flag,
  input logic          bus_req,
  input logic          bus_gnt,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] bus_rdata,
  input logic          cfg_we,
  input logic [2:0]    cfg_addr,
  input logic          cfg_bit0
);

  logic irq_clr;
  assign irq_clr = cfg_we && (cfg_addr == 3'd4) && cfg_bit0;

  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_gnt |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

  p_read_then_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_gnt && !bus_we |=> bus_req && bus_we);

  p_copy_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_gnt && !bus_we |=> bus_wdata == $past(bus_rdata));

  p_irq_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !irq_clr |=> irq);

  p_irq_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> !bus_req);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_req);

  p_err_no_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> !bus_req);

endmodule

bind dma_engine dma_engine_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .busy      (busy),
  .irq       (irq),
  .err_flag  (err_q),
  .bus_req   (bus_req),
  .bus_gnt   (bus_gnt),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .cfg_we    (cfg_we),
  .cfg_addr  (cfg_addr),
  .cfg_bit0  (cfg_wdata[0])
);

// File: tb/dma_engine_test.sv
module dma_engine_test;
  import dma_pkg::*;

  localparam int AW = 32;
  localparam int CW = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_we;
  logic [2:0]    cfg_addr;
  logic [AW-1:0] cfg_wdata;
  logic [AW-1:0] cfg_rdata;
  logic          irq, bus_req, bus_gnt, bus_we;
  logic [AW-1:0] bus_addr;
  logic [1:0]    bus_size;
  logic [DW-1:0] bus_wdata, bus_rdata;

  always #10 clk = ~clk;  // 50 MHz

  dma_engine #(.AW(AW), .CW(CW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq(irq),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata)
  );

  typedef struct packed {
    logic          we;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic [1:0]    size;
    logic [1:0]    dir;
  } item_t;

  item_t exp_q[$];
  int    checks = 0;
  int    errors = 0;
  int    gnt_mode = 0;
  bit    finished = 0;

  function automatic logic [DW-1:0] mem_val(input logic [AW-1:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h0F0F_1234;
  endfunction

  assign bus_rdata = mem_val(bus_addr);

  function automatic string dir_tag(input logic [1:0] d);
    case (d)
      2'd1:    return "R4";
      2'd2:    return "R5";
      default: return "R3";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // grant source: always granted or pseudo-random stalls
  initial begin
    logic [15:0] lfsr;
    lfsr    = 16'hACE1;
    bus_gnt = 1'b0;
    forever begin
      @(posedge clk);
      #1;
      lfsr    = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      bus_gnt = (gnt_mode == 0) ? 1'b1 : lfsr[0];
    end
  end

  // monitor: compare each granted access against the scoreboard
  initial begin
    logic          prev_stall;
    logic [AW-1:0] prev_addr;
    logic          prev_we;
    prev_stall = 1'b0;
    prev_addr  = '0;
    prev_we    = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (prev_stall) begin
          // R6: request held and address frozen through a stall
          chk(bus_req && bus_addr == prev_addr && bus_we == prev_we, "R6",
              "stalled access changed", {31'd0, bus_req, bus_addr}, {31'd0, 1'b1, prev_addr});
        end
        if (bus_req && bus_gnt) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R2", "unexpected bus access", bus_addr, 64'd0);
          end else begin
            item_t e;
            e = exp_q.pop_front();
            chk(bus_we == e.we, "R2", "access direction", bus_we, e.we);
            chk(bus_addr == e.addr, dir_tag(e.dir), "address", bus_addr, e.addr);
            chk(bus_size == e.size, "R2", "size code", bus_size, e.size);
            if (e.we) chk(bus_wdata == e.data, "R2", "write data", bus_wdata, e.data);
            if (e.we && exp_q.size() == 0)
              chk(irq == 1'b0, "R7", "irq before final write completed", irq, 1'b0);
          end
        end
        prev_stall = bus_req && !bus_gnt;
        prev_addr  = bus_addr;
        prev_we    = bus_we;
      end
    end
  end

  task automatic write_reg(input logic [2:0] a, input logic [AW-1:0] d);
    @(posedge clk);
    #1;
    cfg_we    = 1'b1;
    cfg_addr  = a;
    cfg_wdata = d;
    @(posedge clk);
    #1;
    cfg_we    = 1'b0;
  endtask

  task automatic read_reg(input logic [2:0] a, output logic [AW-1:0] d);
    cfg_addr = a;
    #1;
    d = cfg_rdata;
  endtask

  function automatic logic [AW-1:0] ctl_word(input int w, input int d, input bit go);
    return AW'((go ? 32'h10 : 32'h0) | (d << 2) | w);
  endfunction

  task automatic push_items(input logic [AW-1:0] src, input logic [AW-1:0] dst,
                            input int n, input int w, input int d);
    for (int i = 0; i < n; i++) begin
      item_t r, wr;
      logic [AW-1:0] s, t;
      s = src + ((d == 1) ? 0 : AW'(i * (1 << w)));
      t = dst + ((d == 2) ? 0 : AW'(i * (1 << w)));
      r  = '{we: 1'b0, addr: s, data: '0, size: 2'(w), dir: 2'(d)};
      wr = '{we: 1'b1, addr: t, data: mem_val(s), size: 2'(w), dir: 2'(d)};
      exp_q.push_back(r);
      exp_q.push_back(wr);
    end
  endtask

  task automatic program_start(input logic [AW-1:0] src, input logic [AW-1:0] dst,
                               input int n, input int w, input int d);
    write_reg(RA_SRC, src);
    write_reg(RA_DST, dst);
    write_reg(RA_CNT, AW'(n));
    write_reg(RA_CTRL, ctl_word(w, d, 1'b1));
  endtask

  task automatic finish_xfer(input string tag);
    logic [AW-1:0] st;
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    chk(irq == 1'b1, "R7", {"irq after final write ", tag}, irq, 1'b1);
    read_reg(RA_STAT, st);
    chk(st[2:0] == 3'b001, "R11", {"status after transfer ", tag}, st[2:0], 3'b001);
    write_reg(RA_STAT, 32'h1);
    read_reg(RA_STAT, st);
    chk(st[0] == 1'b0 && irq == 1'b0, "R7", "write-one clear of done", {st[0], irq}, 2'b00);
  endtask

  task automatic run_xfer(input logic [AW-1:0] src, input logic [AW-1:0] dst,
                          input int n, input int w, input int d, input string tag);
    push_items(src, dst, n, w, d);
    program_start(src, dst, n, w, d);
    finish_xfer(tag);
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] rd;
    rst_n     = 1'b0;
    cfg_we    = 1'b0;
    cfg_addr  = RA_STAT;
    cfg_wdata = '0;
    repeat (4) @(posedge clk);
    #1;
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;

    // R1: reset state
    read_reg(RA_STAT, rd);
    chk(rd == '0 && !bus_req && !irq, "R1", "reset state", {rd[2:0], bus_req, irq}, 5'd0);

    // R3: memory-to-memory, 4-byte items, no stalls
    gnt_mode = 0;
    run_xfer(32'h0000_1000, 32'h0000_8000, 3, 2, 0, "m2m word");

    // R4: peripheral-to-memory, byte items, random stalls
    gnt_mode = 1;
    run_xfer(32'h4000_0010, 32'h0000_2001, 5, 0, 1, "p2m byte");

    // R5: memory-to-peripheral, half-word items, random stalls
    run_xfer(32'h0000_3002, 32'h4000_0020, 4, 1, 2, "m2p half");

    // boundary: one item
    gnt_mode = 0;
    run_xfer(32'h0000_0007, 32'h0000_0103, 1, 0, 0, "single item");

    // R10, R11: writes while busy are ignored
    gnt_mode = 1;
    push_items(32'h0000_5000, 32'h0000_6000, 6, 2, 0);
    program_start(32'h0000_5000, 32'h0000_6000, 6, 2, 0);
    read_reg(RA_STAT, rd);
    chk(rd[2] == 1'b1, "R11", "busy during transfer", rd[2], 1'b1);
    write_reg(RA_SRC, 32'hDEAD_0000);
    write_reg(RA_CTRL, ctl_word(0, 1, 1'b1));
    read_reg(RA_SRC, rd);
    chk(rd == 32'h0000_5000, "R10", "source register while busy", rd, 32'h0000_5000);
    read_reg(RA_CTRL, rd);
    chk(rd[3:0] == 4'h2, "R10", "control register while busy", rd[3:0], 4'h2);
    finish_xfer("busy writes");

    // R8: misaligned word start
    gnt_mode = 0;
    write_reg(RA_SRC, 32'h0000_0102);
    write_reg(RA_DST, 32'h0000_0200);
    write_reg(RA_CNT, 32'd3);
    write_reg(RA_CTRL, ctl_word(2, 0, 1'b1));
    read_reg(RA_STAT, rd);
    chk(rd[2:0] == 3'b010, "R8", "misaligned source status", rd[2:0], 3'b010);
    repeat (4) @(negedge clk);
    chk(!bus_req, "R8", "bus idle after misaligned start", bus_req, 1'b0);
    write_reg(RA_STAT, 32'h2);
    read_reg(RA_STAT, rd);
    chk(rd[1] == 1'b0, "R8", "write-one clear of error", rd[1], 1'b0);

    // R8: misaligned half-word destination
    write_reg(RA_SRC, 32'h0000_0100);
    write_reg(RA_DST, 32'h0000_0201);
    write_reg(RA_CTRL, ctl_word(1, 0, 1'b1));
    read_reg(RA_STAT, rd);
    chk(rd[2:0] == 3'b010, "R8", "misaligned destination status", rd[2:0], 3'b010);
    write_reg(RA_STAT, 32'h2);

    // R8: invalid size code
    write_reg(RA_DST, 32'h0000_0200);
    write_reg(RA_CTRL, ctl_word(3, 0, 1'b1));
    read_reg(RA_STAT, rd);
    chk(rd[2:0] == 3'b010, "R8", "invalid size code status", rd[2:0], 3'b010);
    write_reg(RA_STAT, 32'h2);

    // R9: zero count completes at once
    write_reg(RA_CNT, 32'd0);
    write_reg(RA_CTRL, ctl_word(0, 0, 1'b1));
    read_reg(RA_STAT, rd);
    chk(rd[2:0] == 3'b001 && irq, "R9", "zero count done", {rd[2:0], irq}, 4'b0011);
    repeat (4) @(negedge clk);
    chk(!bus_req, "R9", "no bus access for zero count", bus_req, 1'b0);
    write_reg(RA_STAT, 32'h1);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R2", "scoreboard drained", exp_q.size(), 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule